// File: doc/BRIEF.md
# Carry-free signed-digit adder

This block adds two N-digit numbers whose digits each take the value -1, 0 or +1. The whole datapath is combinational, and no carry travels more than one digit position. The result is an (N+1)-digit number in the same digit form. Each digit is carried on two wires, and digit i of a word sits in bits [2i+1:2i].

The adder works in three steps. First, each input digit pair is recoded into three binary bits. Two of them give the class of the pair: double, single or zero. The third is a binary reference digit that is handed to the next higher position. Second, each position uses its own class together with the reference digit from below to choose an intermediate carry and sum. The choice keeps the sum on the side that the neighbour's carry can never push out of range. Third, each result digit is the position's sum plus the carry from the position below. The top digit is the top carry alone.

The adder is meant to sit inside a larger datapath that keeps operands in signed-digit form. Its delay is fixed and does not depend on N.

Top module: `sd_cf_adder`

## Requirements
- R1: Digit code is 2'b00 = 0, 2'b01 = +1 and 2'b11 = -1. No digit of `z_o` ever carries 2'b10.
- R2: An input digit coded 2'b10 is read as 0.
- R3: The value of `z_o`, summed as z_i times 2^i over its N+1 digits, equals the value of `x_i` plus the value of `y_i`.
- R4: The reference digit for position i+1 is 1 when at least one digit of pair i is +1, and 0 otherwise. The reference digit for position 0 is 0.
- R5: For each position, 2*c_{i+1} + s_i = x_i + y_i. A pair sum of +2 or -2 gives carry +1 or -1 with sum 0. A pair sum of 0 gives carry 0 and sum 0. For a pair sum of +1 or -1, the sum digit is taken from {-1,0} when the incoming reference digit is 1 and from {0,1} when it is 0.
- R6: z_i = s_i + c_i for i < N, with c_0 = 0, and z_N = c_N. Every s_i + c_i lies in {-1,0,1}, so no further carry arises.
- R7: With N = 8, the operands 10000101 (133) and 00100111 (39), with every 1 coded as +1, give a result worth 172.
- R8: Operands that are all -1 or all +1 give the exact extreme sums: all +1 plus all +1 yields z_0 = 0 and every other digit +1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | 2*N | First operand, N signed digits |
| y_i | input | 2*N | Second operand, N signed digits |
| z_o | output | 2*N+2 | Sum, N+1 signed digits |

## Verification
The bench builds two copies of the adder. The first uses N = 3, which makes a full sweep of all 729 operand pairs practical. That sweep checks every pair class against every incoming reference digit at every position, and checks each result digit exactly as well as by value. The second uses the default N = 8, where random operands, the worked example, all-(+1) and all-(-1) extremes, and inputs seeded with the unused 2'b10 code exercise the full-width reference and carry chain.

// File: rtl/sd_adder_pkg.sv
// Package for the signed-digit adder: digit codes, the pair classes
// produced by the recoder, and helpers that convert between code and value.
// Assumes digit values never leave the range -2..2.
package sd_adder_pkg;

    typedef logic [1:0]        sd_code_t;
    typedef logic signed [2:0] sd_val_t;

    localparam sd_code_t SD_ZERO = 2'b00;
    localparam sd_code_t SD_POS  = 2'b01;
    localparam sd_code_t SD_NEG  = 2'b11;

    // Class of an input pair (the u,v bits): which carry/sum outcome applies.
    typedef enum logic [1:0] {
        PC_DOUBLE = 2'b00,   // both digits equal and nonzero (+2 or -2)
        PC_SINGLE = 2'b01,   // exactly one nonzero digit (+1 or -1)
        PC_ZERO   = 2'b10    // digits cancel or both zero
    } pair_class_e;

    typedef struct packed {
        pair_class_e cls;    // outcome selector
        logic        w;      // reference digit handed to the next position
    } pair_rec_t;

    // Code to value; the unused code 2'b10 reads as zero.
    function automatic sd_val_t sd_decode(sd_code_t c);
        case (c)
            SD_POS:  return 3'sd1;
            SD_NEG:  return -3'sd1;
            default: return 3'sd0;
        endcase
    endfunction

    // Value to code; callers only pass -1, 0 or +1.
    function automatic sd_code_t sd_encode(sd_val_t v);
        if (v == 3'sd1)       return SD_POS;
        else if (v == -3'sd1) return SD_NEG;
        else                  return SD_ZERO;
    endfunction

endpackage

// File: rtl/sd_pair_recode.sv
// Recodes one input digit pair into a class (u,v) and a reference digit w.
// Assumes the digit code of the package; 2'b10 is handled as zero.
module sd_pair_recode
    import sd_adder_pkg::*;
(
    input  sd_code_t  xd,
    input  sd_code_t  yd,
    output pair_rec_t rec
);

    logic x_pos, x_neg, y_pos, y_neg;
    logic is_double, is_single;

    // Split each code into its plus and minus flags.
    always_comb begin
        x_pos = (xd == SD_POS);
        x_neg = (xd == SD_NEG);
        y_pos = (yd == SD_POS);
        y_neg = (yd == SD_NEG);
    end

    // Classify the pair and form the upward reference digit.
    always_comb begin
        is_double = (x_pos & y_pos) | (x_neg & y_neg);
        is_single = (x_pos | x_neg) ^ (y_pos | y_neg);
        rec.w     = x_pos | y_pos;
        if (is_double)      rec.cls = PC_DOUBLE;
        else if (is_single) rec.cls = PC_SINGLE;
        else                rec.cls = PC_ZERO;
    end

endmodule

// File: rtl/sd_carry_sum.sv
// Chooses the intermediate carry and sum for one position from the pair
// record and the reference digit arriving from the position below.
// Assumes the class encoding of sd_adder_pkg.
module sd_carry_sum
    import sd_adder_pkg::*;
(
    input  pair_rec_t rec,
    input  logic      ref_in,
    output sd_val_t   carry_o,
    output sd_val_t   sum_o
);

    // Select the outcome; for single pairs the reference steers the sum sign.
    always_comb begin
        carry_o = 3'sd0;
        sum_o   = 3'sd0;
        case (rec.cls)
            PC_DOUBLE: carry_o = rec.w ? 3'sd1 : -3'sd1;
            PC_SINGLE: begin
                sum_o = ref_in ? -3'sd1 : 3'sd1;
                if (rec.w) carry_o = ref_in ? 3'sd1 : 3'sd0;
                else       carry_o = ref_in ? 3'sd0 : -3'sd1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sd_digit_merge.sv
// Adds a position's sum digit to the carry from below into one result digit.
// Assumes the two inputs never total outside -1..+1.
module sd_digit_merge
    import sd_adder_pkg::*;
(
    input  sd_val_t  sum_i,
    input  sd_val_t  carry_i,
    output sd_code_t z
);

    sd_val_t total;

    // Form and encode the result digit.
    always_comb begin
        total = sum_i + carry_i;
        z     = sd_encode(total);
    end

    // The carry from below never pushes the sum out of digit range.
    always_comb begin
        assert_digit_in_range_R6: assert (total >= -3'sd1 && total <= 3'sd1)
            else $error("merge total %0d out of range", total);
    end

endmodule

// File: rtl/sd_cf_adder.sv
// Carry-free adder for two N-digit signed-digit operands, combinational.
// Digit i occupies bits [2i+1:2i]. The output has N+1 digits.
// Assumes the digit code 00=0, 01=+1, 11=-1.
module sd_cf_adder
    import sd_adder_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [2*N-1:0] x_i,
    input  logic [2*N-1:0] y_i,
    output logic [2*N+1:0] z_o
);

    localparam int ZD = N + 1;

    pair_rec_t rec_w   [N];
    logic      ref_w   [ZD];
    sd_val_t   carry_w [ZD];
    sd_val_t   sum_w   [N];

    assign ref_w[0]   = 1'b0;
    assign carry_w[0] = 3'sd0;

    for (genvar i = 0; i < N; i++) begin : g_pos
        sd_pair_recode u_rec (
            .xd  (x_i[2*i +: 2]),
            .yd  (y_i[2*i +: 2]),
            .rec (rec_w[i])
        );

        assign ref_w[i+1] = rec_w[i].w;

        sd_carry_sum u_cs (
            .rec     (rec_w[i]),
            .ref_in  (ref_w[i]),
            .carry_o (carry_w[i+1]),
            .sum_o   (sum_w[i])
        );

        sd_digit_merge u_mrg (
            .sum_i   (sum_w[i]),
            .carry_i (carry_w[i]),
            .z       (z_o[2*i +: 2])
        );

        // Guard the per-position rules across recoder, selector and merge.
        always_comb begin
            assert_pair_identity_R5: assert (2*int'(carry_w[i+1]) + int'(sum_w[i]) ==
                    int'(sd_decode(x_i[2*i +: 2])) + int'(sd_decode(y_i[2*i +: 2])))
                else $error("position %0d breaks 2c+s identity", i);
            assert_sum_window_R5: assert (ref_w[i] ? (sum_w[i] <= 3'sd0) : (sum_w[i] >= 3'sd0))
                else $error("position %0d sum outside reference window", i);
            assert_ref_rule_R4: assert (rec_w[i].w ==
                    ((x_i[2*i +: 2] == SD_POS) || (y_i[2*i +: 2] == SD_POS)))
                else $error("position %0d reference digit wrong", i);
            assert_no_bad_code_R1: assert (z_o[2*i +: 2] != 2'b10)
                else $error("position %0d emits unused code", i);
        end
    end

    // The top digit is the last carry alone.
    always_comb begin
        z_o[2*N +: 2] = sd_encode(carry_w[N]);
    end

endmodule

// File: tb/tb_sd_cf_adder.sv
// Bench: full sweep at N=3, directed and random vectors at N=8.
module tb_sd_cf_adder;
    localparam int NW = 8;
    localparam int NS = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic [2*NW-1:0] xw = '0, yw = '0;
    logic [2*NW+1:0] zw;
    logic [2*NS-1:0] xs = '0, ys = '0;
    logic [2*NS+1:0] zs;

    sd_cf_adder #(.N(NW)) dut       (.x_i(xw), .y_i(yw), .z_o(zw));
    sd_cf_adder #(.N(NS)) dut_small (.x_i(xs), .y_i(ys), .z_o(zs));

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    function automatic int dv(logic [1:0] c);
        case (c)
            2'b01:   return 1;
            2'b11:   return -1;
            default: return 0;
        endcase
    endfunction

    function automatic logic [1:0] enc(int v);
        if (v == 1)       return 2'b01;
        else if (v == -1) return 2'b11;
        else              return 2'b00;
    endfunction

    // Digit-exact expectation from the R4/R5/R6 rules.
    function automatic logic [17:0] model(int n, logic [17:0] xa, logic [17:0] ya);
        logic [17:0] zr = '0;
        int r = 0;
        int cprev = 0;
        for (int i = 0; i < n; i++) begin
            int a = dv(xa[2*i +: 2]);
            int b = dv(ya[2*i +: 2]);
            int p = a + b;
            int c = 0;
            int s = 0;
            if (p == 2)       c = 1;
            else if (p == -2) c = -1;
            else if (p == 1)  begin if (r == 1) begin c = 1; s = -1; end else begin c = 0; s = 1; end end
            else if (p == -1) begin if (r == 1) begin c = 0; s = -1; end else begin c = -1; s = 1; end end
            zr[2*i +: 2] = enc(s + cprev);
            cprev = c;
            r = (a == 1 || b == 1) ? 1 : 0;
        end
        zr[2*n +: 2] = enc(cprev);
        return zr;
    endfunction

    function automatic int sdval(int n, logic [17:0] v);
        int acc = 0;
        for (int i = n - 1; i >= 0; i--) acc = 2*acc + dv(v[2*i +: 2]);
        return acc;
    endfunction

    function automatic logic [1:0] rnd_code();
        case ($urandom_range(2))
            0:       return 2'b00;
            1:       return 2'b01;
            default: return 2'b11;
        endcase
    endfunction

    function automatic logic [15:0] bin_to_sd(int v);
        logic [15:0] r = '0;
        for (int i = 0; i < 8; i++) r[2*i +: 2] = v[i] ? 2'b01 : 2'b00;
        return r;
    endfunction

    // Three checks per vector: legal codes (R1), value (R3), exact digits.
    task automatic judge(int n, logic [17:0] xa, logic [17:0] ya, logic [17:0] za, string req);
        logic [17:0] mask = (18'h1 << (2*n + 2)) - 18'h1;
        logic [17:0] ez = model(n, xa, ya);
        int got = sdval(n + 1, za);
        int want = sdval(n, xa) + sdval(n, ya);
        bit bad = 1'b0;
        for (int i = 0; i <= n; i++) if (za[2*i +: 2] == 2'b10) bad = 1'b1;
        checks++;
        if (bad) begin fails++; $display("FAIL R1 (%s) unused code: actual %h expected no 2'b10", req, za & mask); end
        checks++;
        if (got != want) begin fails++; $display("FAIL R3 (%s) value: actual %0d expected %0d", req, got, want); end
        checks++;
        if ((za & mask) != ez) begin fails++; $display("FAIL %s digits: actual %h expected %h", req, za & mask, ez); end
    endtask

    task automatic run_w(logic [15:0] xa, logic [15:0] ya, string req);
        @(negedge clk);
        xw = xa; yw = ya;
        @(posedge clk); #1;
        judge(NW, {2'b00, xa}, {2'b00, ya}, zw, req);
    endtask

    task automatic run_s(logic [5:0] xa, logic [5:0] ya, string req);
        @(negedge clk);
        xs = xa; ys = ya;
        @(posedge clk); #1;
        judge(NS, {12'h0, xa}, {12'h0, ya}, {10'h0, zs}, req);
    endtask

    function automatic logic [5:0] tri_digits(int v);
        logic [5:0] r = '0;
        int t = v;
        for (int i = 0; i < NS; i++) begin
            r[2*i +: 2] = (t % 3 == 0) ? 2'b00 : (t % 3 == 1) ? 2'b01 : 2'b11;
            t = t / 3;
        end
        return r;
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        #1;
        // Idle state: zero operands give an all-zero result (R1, R3).
        checks++;
        if (zw != '0) begin fails++; $display("FAIL R1 idle output: actual %h expected 0", zw); end

        // R7 worked example.
        run_w(bin_to_sd(133), bin_to_sd(39), "R7");
        // R8 extremes.
        run_w(16'h5555, 16'h5555, "R8 all+1");
        checks++;
        if (zw != 18'h15554) begin fails++; $display("FAIL R8 all+1 digits: actual %h expected %h", zw, 18'h15554); end
        run_w(16'hFFFF, 16'hFFFF, "R8 all-1");
        run_w(16'h5555, 16'hFFFF, "R8 cancel");
        // R4 reference steering: +1 below a single pair flips the sum sign.
        run_w(16'h0005, 16'h0000, "R4");
        checks++;
        if (zw[5:0] != 6'b01_11_01) begin fails++; $display("FAIL R4 steering: actual %b expected 011101", zw[5:0]); end
        // R2 unused input code read as zero.
        run_w(16'hAAAA, 16'h5555, "R2");
        run_w(16'h2A81, 16'hB2E4, "R2 mixed");

        // R5/R6 full sweep at N=3.
        for (int a = 0; a < 27; a++)
            for (int b = 0; b < 27; b++)
                run_s(tri_digits(a), tri_digits(b), "R5/R6 sweep");

        // R3/R6 random vectors at N=8.
        for (int k = 0; k < 2000; k++) begin
            logic [15:0] ra, rb;
            for (int i = 0; i < NW; i++) begin
                ra[2*i +: 2] = rnd_code();
                rb[2*i +: 2] = rnd_code();
            end
            run_w(ra, rb, "R6 random");
        end

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog (all requirements): actual hung expected done");
            summary();
            $finish;
        end
    end

endmodule